// File: doc/BRIEF.md
# Four-Best Track Candidate Sorter

The block takes one event per clock cycle. An event is a set of up to 24 track candidates, each a 31-bit record with a per-slot valid bit. It returns the four candidates with the highest rank. A per-slot ghost mask, computed elsewhere, is applied first. Masked slots are removed from the event before any ranking takes place.

Ranking is done by a chain of four single-winner selectors. Each selector picks the best remaining candidate and clears that slot from the pool it hands to the next selector. Two selectors share each of the first two pipeline steps. A third step uses the winning slot indices to steer the stored records onto the four output ports. The result is a fixed latency of three register stages, and a new event can enter on every cycle.

Top module: `trackBestSorter`

## Requirements
- R1: The rank of a candidate is bits [7:0] of its record: quality in bits [7:5] and transverse momentum in bits [4:0], compared as one unsigned 8-bit number. Output port 0 carries the highest-ranked valid candidate.
- R2: A slot whose ghostMask bit is 1 never appears on any output, whatever its rank.
- R3: A slot whose inValid bit is 0 never appears on any output.
- R4: Among candidates of equal rank, the one with the lower slot index takes the earlier output port.
- R5: Ranks on valid output ports do not increase from port 0 to port 3. No slot index appears on two valid ports. A valid port is never preceded by an invalid one.
- R6: When fewer than four eligible candidates exist, each unused port reports hit 0, index 0 and an all-zero record.
- R7: An event captured with inEvent high at clock edge n appears on the outputs after edge n+2 (three register stages). outEvent is high for exactly that cycle.
- R8: Events presented on consecutive cycles each produce their own correct result on consecutive cycles.
- R9: While outEvent is low, the outputs keep the previous result, whatever the inputs do.
- R10: During and after reset, with no event yet, all outputs are zero.
- R11: On a valid port, outIdx is the 5-bit slot number of the winner and outRec is that slot's full 31-bit record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inEvent | input | 1 | Event present on the inputs this cycle |
| inValid | input | 24 | Per-slot candidate valid |
| ghostMask | input | 24 | Per-slot ghost cancel (1 = drop slot) |
| inRec | input | 744 | Slot j record at bits [31*j+30 : 31*j] |
| outEvent | output | 1 | Result of an event is on the outputs |
| outHit | output | 4 | Port k holds a winner |
| outIdx | output | 20 | Port k winner slot at bits [5*k+4 : 5*k] |
| outRec | output | 124 | Port k winner record at bits [31*k+30 : 31*k] |

## Verification
The bench builds the block with its default parameters: 24 slots, 4 outputs, 31-bit records and an 8-bit rank. These are the sizes at which the selector split across two pipeline steps and the index-driven output steering actually work. At these sizes, ties across a full 24-slot pool, masks on the top-ranked slots, and pools of zero to three eligible candidates can all be reached. Streams of back-to-back events exercise all three stages holding different events at the same time.

// File: rtl/trkSortPkg.sv
package trkSortPkg;
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
  } stageStrobes_t;
endpackage

// File: rtl/trkSelector.sv
module trkSelector #(
  parameter int NS = 24,
  parameter int KW = 8,
  localparam int IW = $clog2(NS)
) (
  input  logic [NS-1:0]    poolIn,
  input  logic [NS*KW-1:0] rankFlat,
  output logic             hit,
  output logic [IW-1:0]    idx,
  output logic [NS-1:0]    poolOut
);
  logic [KW-1:0] bestRank;
  always_comb begin
    hit = 1'b0;
    idx = '0;
    bestRank = '0;
    for (int j = NS - 1; j >= 0; j--) begin
      if (poolIn[j] && (!hit || rankFlat[j*KW +: KW] >= bestRank)) begin
        hit = 1'b1;
        idx = IW'(j);
        bestRank = rankFlat[j*KW +: KW];
      end
    end
    poolOut = poolIn;
    if (hit) poolOut[idx] = 1'b0;
  end
endmodule

// File: rtl/trkSortControl.sv
module trkSortControl
  import trkSortPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inEvent,
  output stageStrobes_t strobes,
  output logic          outEvent
);
  logic [2:0] evPipe;
  always_ff @(posedge clk) begin
    if (!rstN) evPipe <= '0;
    else       evPipe <= {evPipe[1:0], inEvent};
  end
  assign strobes.ld1 = inEvent;
  assign strobes.ld2 = evPipe[0];
  assign strobes.ld3 = evPipe[1];
  assign outEvent    = evPipe[2];

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    outEvent |-> $past(inEvent, 3));
endmodule

// File: rtl/trkSortDatapath.sv
module trkSortDatapath
  import trkSortPkg::*;
#(
  parameter int NS = 24,
  parameter int NO = 4,
  parameter int RW = 31,
  parameter int KW = 8,
  localparam int IW = $clog2(NS),
  localparam int HALF = NO / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  stageStrobes_t strobes,
  input  logic [NS-1:0]    inValid,
  input  logic [NS-1:0]    ghostMask,
  input  logic [NS*RW-1:0] inRec,
  output logic [NO-1:0]    outHit,
  output logic [NO*IW-1:0] outIdx,
  output logic [NO*RW-1:0] outRec
);
  logic [RW-1:0] inArr [NS];
  logic [RW-1:0] p1Rec [NS];
  logic [RW-1:0] p2Rec [NS];
  logic [NS*KW-1:0] rankIn, rankP1;
  logic [NS-1:0] liveIn, p1Valid;
  logic [NS-1:0] poolSrc [NO];
  logic [NS-1:0] poolDst [NO];
  logic [NO-1:0] selHit;
  logic [IW-1:0] selIdx [NO];
  logic [HALF-1:0] p1Hit;
  logic [IW-1:0] p1Idx [HALF];
  logic [NO-1:0] p2Hit;
  logic [IW-1:0] p2Idx [NO];
  logic [NO-1:0] oHit;
  logic [IW-1:0] oIdx [NO];
  logic [RW-1:0] oRec [NO];

  // Ghost clearing in front of the first selector
  assign liveIn = inValid & ~ghostMask;

  for (genvar j = 0; j < NS; j++) begin : g_slot
    assign inArr[j] = inRec[j*RW +: RW];
    assign rankIn[j*KW +: KW] = inArr[j][KW-1:0];
    assign rankP1[j*KW +: KW] = p1Rec[j][KW-1:0];
  end

  // Selector chain, split across two pipeline steps
  for (genvar i = 0; i < NO; i++) begin : g_sel
    if (i == 0) begin : g_first
      assign poolSrc[i] = liveIn;
    end else if (i == HALF) begin : g_cut
      assign poolSrc[i] = p1Valid;
    end else begin : g_chain
      assign poolSrc[i] = poolDst[i-1];
    end
    if (i < HALF) begin : g_early
      trkSelector #(.NS(NS), .KW(KW)) uSel (
        .poolIn(poolSrc[i]), .rankFlat(rankIn),
        .hit(selHit[i]), .idx(selIdx[i]), .poolOut(poolDst[i]));
    end else begin : g_late
      trkSelector #(.NS(NS), .KW(KW)) uSel (
        .poolIn(poolSrc[i]), .rankFlat(rankP1),
        .hit(selHit[i]), .idx(selIdx[i]), .poolOut(poolDst[i]));
    end
  end

  // Step 1: ghost clear + first half of the selectors
  always_ff @(posedge clk) begin
    if (!rstN) begin
      p1Valid <= '0;
      p1Hit   <= '0;
      for (int j = 0; j < NS; j++) p1Rec[j] <= '0;
      for (int i = 0; i < HALF; i++) p1Idx[i] <= '0;
    end else if (strobes.ld1) begin
      p1Valid <= poolDst[HALF-1];
      p1Hit   <= selHit[HALF-1:0];
      for (int j = 0; j < NS; j++) p1Rec[j] <= inArr[j];
      for (int i = 0; i < HALF; i++) p1Idx[i] <= selIdx[i];
    end
  end

  // Step 2: second half of the selectors
  always_ff @(posedge clk) begin
    if (!rstN) begin
      p2Hit <= '0;
      for (int j = 0; j < NS; j++) p2Rec[j] <= '0;
      for (int i = 0; i < NO; i++) p2Idx[i] <= '0;
    end else if (strobes.ld2) begin
      for (int j = 0; j < NS; j++) p2Rec[j] <= p1Rec[j];
      for (int i = 0; i < NO; i++) begin
        p2Hit[i] <= (i < HALF) ? p1Hit[i] : selHit[i];
        p2Idx[i] <= (i < HALF) ? p1Idx[i] : selIdx[i];
      end
    end
  end

  // Step 3: index-steered output multiplexers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      oHit <= '0;
      for (int i = 0; i < NO; i++) begin
        oIdx[i] <= '0;
        oRec[i] <= '0;
      end
    end else if (strobes.ld3) begin
      oHit <= p2Hit;
      for (int i = 0; i < NO; i++) begin
        oIdx[i] <= p2Hit[i] ? p2Idx[i] : '0;
        oRec[i] <= p2Hit[i] ? p2Rec[p2Idx[i]] : '0;
      end
    end
  end

  assign outHit = oHit;
  for (genvar i = 0; i < NO; i++) begin : g_out
    assign outIdx[i*IW +: IW] = oIdx[i];
    assign outRec[i*RW +: RW] = oRec[i];
  end

  assert_ghost_cleared_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.ld1 |=> (p1Valid & $past(ghostMask)) == '0);

  for (genvar i = 0; i < NO; i++) begin : g_chk
    assert_empty_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
      !oHit[i] |-> (oRec[i] == '0 && oIdx[i] == '0));
    if (i + 1 < NO) begin : g_pair
      assert_rank_order_R5: assert property (@(posedge clk) disable iff (!rstN)
        oHit[i+1] |-> (oHit[i] && oRec[i][KW-1:0] >= oRec[i+1][KW-1:0]));
      assert_tie_low_index_R4: assert property (@(posedge clk) disable iff (!rstN)
        (oHit[i+1] && oRec[i][KW-1:0] == oRec[i+1][KW-1:0]) |-> oIdx[i] < oIdx[i+1]);
    end
    for (genvar k = i + 1; k < NO; k++) begin : g_dup
      assert_no_dup_R5: assert property (@(posedge clk) disable iff (!rstN)
        (oHit[i] && oHit[k]) |-> oIdx[i] != oIdx[k]);
    end
  end
endmodule

// File: rtl/trackBestSorter.sv
module trackBestSorter
  import trkSortPkg::*;
#(
  parameter int NUM_SLOTS = 24,
  parameter int NUM_OUT   = 4,
  parameter int REC_W     = 31,
  parameter int RANK_W    = 8,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inEvent,
  input  logic [NUM_SLOTS-1:0]       inValid,
  input  logic [NUM_SLOTS-1:0]       ghostMask,
  input  logic [NUM_SLOTS*REC_W-1:0] inRec,
  output logic                       outEvent,
  output logic [NUM_OUT-1:0]         outHit,
  output logic [NUM_OUT*IDX_W-1:0]   outIdx,
  output logic [NUM_OUT*REC_W-1:0]   outRec
);
  stageStrobes_t strobes;

  trkSortControl uCtrl (
    .clk(clk), .rstN(rstN), .inEvent(inEvent),
    .strobes(strobes), .outEvent(outEvent));

  trkSortDatapath #(.NS(NUM_SLOTS), .NO(NUM_OUT), .RW(REC_W), .KW(RANK_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .inValid(inValid), .ghostMask(ghostMask), .inRec(inRec),
    .outHit(outHit), .outIdx(outIdx), .outRec(outRec));
endmodule

// File: tb/tb_trackBestSorter.sv
module tb_trackBestSorter;
  localparam int NS = 24, NO = 4, RW = 31, IW = 5;

  logic clk = 1'b0, rstN = 1'b0, inEvent = 1'b0;
  logic [NS-1:0] inValid = '0, ghostMask = '0;
  logic [NS*RW-1:0] inRec = '0;
  logic outEvent;
  logic [NO-1:0] outHit;
  logic [NO*IW-1:0] outIdx;
  logic [NO*RW-1:0] outRec;

  trackBestSorter dut (.*);

  always #5 clk = ~clk;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  logic [NS-1:0] stV, stG;
  logic [RW-1:0] stR [NS];
  logic [NO-1:0] exHit;
  logic [IW-1:0] exIdx [NO];
  logic [RW-1:0] exRec [NO];

  logic [NS-1:0] qV [8];
  logic [NS-1:0] qG [8];
  logic [RW-1:0] qR [8][NS];

  function automatic logic [31:0] nextRand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference: repeated strict-greater scan in ascending slot order
  task automatic model();
    logic [NS-1:0] taken;
    taken = '0;
    for (int k = 0; k < NO; k++) begin
      int best;
      best = -1;
      for (int j = 0; j < NS; j++)
        if (stV[j] && !stG[j] && !taken[j] &&
            (best < 0 || stR[j][7:0] > stR[best][7:0])) best = j;
      exHit[k] = (best >= 0);
      exIdx[k] = (best >= 0) ? IW'(best) : '0;
      exRec[k] = (best >= 0) ? stR[best] : '0;
      if (best >= 0) taken[best] = 1'b1;
    end
  endtask

  task automatic drive();
    inValid = stV;
    ghostMask = stG;
    for (int j = 0; j < NS; j++) inRec[j*RW +: RW] = stR[j];
  endtask

  task automatic checkOut(input string tag);
    model();
    for (int k = 0; k < NO; k++) begin
      chk({tag, " hit"}, 64'(outHit[k]), 64'(exHit[k]));
      chk({tag, " idx R11"}, 64'(outIdx[k*IW +: IW]), 64'(exIdx[k]));
      chk({tag, " rec R11"}, 64'(outRec[k*RW +: RW]), 64'(exRec[k]));
    end
  endtask

  task automatic genRand(input int density);
    for (int j = 0; j < NS; j++) begin
      stR[j] = RW'(nextRand());
      stV[j] = (nextRand() % 100) < density;
      stG[j] = 1'b0;
    end
  endtask

  // one event: outEvent must rise on the third negedge after driving (R7)
  task automatic runOne(input string tag);
    @(negedge clk);
    drive();
    inEvent = 1'b1;
    @(negedge clk);
    inEvent = 1'b0;
    chk("R7 early1", 64'(outEvent), 64'(0));
    @(negedge clk);
    chk("R7 early2", 64'(outEvent), 64'(0));
    @(negedge clk);
    chk("R7 outEvent", 64'(outEvent), 64'(1));
    checkOut(tag);
  endtask

  task automatic testReset();
    chk("R10 outEvent", 64'(outEvent), 64'(0));
    chk("R10 hit", 64'(outHit), 64'(0));
    chk("R10 idx", 64'(outIdx), 64'(0));
    chk("R10 rec", 64'(outRec), 64'(0));
  endtask

  task automatic testRandom();
    for (int n = 0; n < 6; n++) begin
      genRand(40 + n * 10);
      runOne("R1 R3 R5 random");
    end
  endtask

  task automatic testGhost();
    genRand(100);
    stR[3][7:0] = 8'hFF; stR[9][7:0] = 8'hFE; stR[17][7:0] = 8'hFD;
    stG[3] = 1'b1; stG[17] = 1'b1;
    runOne("R2 ghost");
    chk("R2 slot9 first", 64'(outIdx[IW-1:0]), 64'(9));
  endtask

  task automatic testTie();
    for (int j = 0; j < NS; j++) begin
      stR[j] = {RW'(nextRand()) >> 8, 8'h5A};
      stV[j] = 1'b1;
      stG[j] = 1'b0;
    end
    stV[0] = 1'b0; stG[2] = 1'b1;
    runOne("R4 tie");
    chk("R4 order", 64'(outIdx), 64'({5'd5, 5'd4, 5'd3, 5'd1}));
  endtask

  task automatic testSparse();
    genRand(0);
    stV[20] = 1'b1; stR[20][7:0] = 8'h10;
    stV[7]  = 1'b1; stR[7][7:0]  = 8'h80;
    stV[11] = 1'b1; stG[11] = 1'b1;
    runOne("R6 sparse");
    chk("R6 hits", 64'(outHit), 64'(4'b0011));
    genRand(0);
    stG = '1;
    stV = '1;
    runOne("R6 empty");
    chk("R6 allzero", 64'(outRec), 64'(0));
  endtask

  task automatic testStream();
    for (int e = 0; e < 8; e++) begin
      genRand(20 + e * 10);
      for (int j = 0; j < NS; j++) stG[j] = (nextRand() % 5) == 0;
      qV[e] = stV; qG[e] = stG;
      for (int j = 0; j < NS; j++) qR[e][j] = stR[j];
    end
    for (int c = 0; c < 11; c++) begin
      @(negedge clk);
      if (c >= 3) begin
        stV = qV[c-3]; stG = qG[c-3];
        for (int j = 0; j < NS; j++) stR[j] = qR[c-3][j];
        chk("R8 outEvent", 64'(outEvent), 64'(1));
        checkOut("R8 stream");
      end
      if (c < 8) begin
        stV = qV[c]; stG = qG[c];
        for (int j = 0; j < NS; j++) stR[j] = qR[c][j];
        drive();
        inEvent = 1'b1;
      end else inEvent = 1'b0;
    end
  endtask

  task automatic testHold();
    logic [NO*RW-1:0] keepRec;
    logic [NO*IW-1:0] keepIdx;
    logic [NO-1:0] keepHit;
    genRand(70);
    runOne("R9 setup");
    keepRec = outRec; keepIdx = outIdx; keepHit = outHit;
    for (int n = 0; n < 5; n++) begin
      genRand(90);
      drive();
      @(negedge clk);
      chk("R9 noEvent", 64'(outEvent), 64'(0));
      chk("R9 holdHit", 64'(outHit), 64'(keepHit));
      chk("R9 holdIdx", 64'(outIdx), 64'(keepIdx));
      chk("R9 holdRec", 64'(outRec), 64'(keepRec));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRandom();
    testGhost();
    testTie();
    testSparse();
    testStream();
    testHold();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule